// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. Software pulses a go strobe while the block is sampling. The block then opens the sample switch and paces the conversion with a conversion clock. That clock comes either from a programmable divider on the system clock or from a tick supplied by a separate RC oscillator. On each conversion clock it drives a trial code to the external DAC and reads the comparator, deciding one bit per period from the most significant bit down.

The first conversion-clock period after the start lets the holding node settle. The twelve periods after it each resolve one bit, so a conversion spans 13 conversion-clock periods. When the RC source is selected, the block first waits one instruction cycle (a parameterised number of system clocks) before it accepts RC ticks.

The result register keeps its previous value until the final bit is decided. On that same edge it loads the new code, busy drops and the done flag sets. One system clock later the sample switch closes again. The done flag stays set until software clears it with a dedicated strobe.

Top module: `sar_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, sample_o is 1 and busy_o, done_o, result_o and dac_code_o are all 0.
- R2: A go_i pulse seen on a clock edge while sample_o is 1 makes busy_o 1 and sample_o 0 from that edge onward.
- R3: With clk_sel_i = 0, one conversion-clock period is 2^(div_sel_i+1) system clocks for div_sel_i 0..5, and 64 system clocks for div_sel_i 6 or 7. Completion falls exactly 13 periods after the go edge.
- R4: With clk_sel_i = 1, the block waits INSTR_CLKS (default 4) system clocks after the go edge and ignores rc_tick_i during that wait. After the wait, each clock with rc_tick_i = 1 is one conversion-clock period.
- R5: The first period drives dac_code_o = 0x800. Each later period keeps the current trial bit when comp_i = 1 (input at or above the DAC level) and clears it otherwise, then sets the next lower bit. Bits are decided from bit 11 to bit 0, so the final code is the largest code not above the input.
- R6: result_o keeps its previous value throughout a conversion and loads the final code on the completion edge.
- R7: On the completion edge busy_o goes to 0 and done_o goes to 1.
- R8: sample_o stays 0 for the one system clock after completion and returns to 1 on the next edge.
- R9: A go_i pulse while busy_o is 1 changes neither the completion time nor the result.
- R10: done_o stays 1 until a done_clr_i pulse; a new go_i does not clear it.
- R11: Asserting rst_ni during a conversion aborts it at once and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start strobe written by software |
| done_clr_i | input | 1 | Clears the done flag |
| clk_sel_i | input | 1 | 0: divided system clock, 1: RC tick |
| div_sel_i | input | 3 | Divider select, ratio 2^(value+1), capped at 64 |
| rc_tick_i | input | 1 | One-cycle tick from the RC oscillator domain |
| comp_i | input | 1 | Comparator, 1 when input is at or above the DAC level |
| dac_code_o | output | 12 | Trial code driven to the DAC |
| sample_o | output | 1 | Sample switch closed when 1 |
| result_o | output | 12 | Conversion result register |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Completion flag, sticky |

## Verification
The bench builds the block with its default parameters: a 12-bit result, a 3-bit divider select and a four-clock instruction cycle. With these values every divider ratio, including the clamped select codes 6 and 7, completes in at most 832 clocks. Random inputs therefore cover both code extremes and the mid-scale boundary. The short RC wait makes it possible to count exactly the cycles in which RC ticks must be ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_FIN  = 2'd3
  } state_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV_SEL_W = 3,
  parameter int MAX_SEL   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 rc_mode_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 rc_tick_i,
  output logic                 tick_o
);
  localparam int CNT_W = MAX_SEL + 1;

  logic [DIV_SEL_W-1:0] sel_eff;
  logic [CNT_W:0]       div_len;
  logic [CNT_W-1:0]     last_cnt, cnt_q;
  logic                 div_tick;

  always_comb begin
    sel_eff  = (div_sel_i > DIV_SEL_W'(MAX_SEL)) ? DIV_SEL_W'(MAX_SEL) : div_sel_i;
    div_len  = (CNT_W+1)'(1) << (sel_eff + 1'b1);
    last_cnt = CNT_W'(div_len - 1'b1);
    div_tick = (cnt_q == last_cnt);
    tick_o   = en_i & (rc_mode_i ? rc_tick_i : div_tick);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || div_tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // divide ratio is at least 2: divided ticks never come back to back
  assert_div_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !rc_mode_i) |=> !tick_o);
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic         comp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] next_code_o,
  output logic         last_o
);
  localparam int SW = $clog2(W + 1);

  logic [SW-1:0] step_q;
  logic [W-1:0]  code_q;

  // step 0 seeds the MSB; step s decides bit W-s and seeds bit W-1-s
  always_comb begin
    next_code_o = code_q;
    for (int b = 0; b < W; b++) begin
      if (b == W - int'(step_q))          next_code_o[b] = comp_i;
      else if (b == W - 1 - int'(step_q)) next_code_o[b] = 1'b1;
    end
    last_o = tick_i && (step_q == SW'(W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      code_q <= '0;
    end else if (start_i) begin
      step_q <= '0;
      code_q <= '0;
    end else if (tick_i) begin
      step_q <= step_q + 1'b1;
      code_q <= next_code_o;
    end
  end

  assign code_o = code_q;

  // the first period must present only the MSB trial
  assert_msb_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_q == '0 && !start_i) |=> (code_o == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int W          = 12,
  parameter int DIV_SEL_W  = 3,
  parameter int MAX_SEL    = 5,
  parameter int INSTR_CLKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 done_clr_i,
  input  logic                 clk_sel_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 rc_tick_i,
  input  logic                 comp_i,
  output logic [W-1:0]         dac_code_o,
  output logic                 sample_o,
  output logic [W-1:0]         result_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int WC_W = (INSTR_CLKS > 1) ? $clog2(INSTR_CLKS) : 1;

  state_e               state_q;
  logic [WC_W-1:0]      wcnt_q;
  logic                 mode_q;
  logic [DIV_SEL_W-1:0] sel_q;
  logic [W-1:0]         result_q, next_code;
  logic                 done_q, start, tick, last;

  assign start = (state_q == ST_IDLE) && go_i;

  sar_tick_gen #(.DIV_SEL_W(DIV_SEL_W), .MAX_SEL(MAX_SEL)) u_tick (
    .clk_i, .rst_ni,
    .en_i      (state_q == ST_CONV),
    .rc_mode_i (mode_q),
    .div_sel_i (sel_q),
    .rc_tick_i,
    .tick_o    (tick)
  );

  sar_reg #(.W(W)) u_sar (
    .clk_i, .rst_ni,
    .start_i     (start),
    .tick_i      (tick),
    .comp_i,
    .code_o      (dac_code_o),
    .next_code_o (next_code),
    .last_o      (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wcnt_q   <= '0;
      mode_q   <= 1'b0;
      sel_q    <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          mode_q  <= clk_sel_i;
          sel_q   <= div_sel_i;
          wcnt_q  <= '0;
          state_q <= clk_sel_i ? ST_WAIT : ST_CONV;
        end
        ST_WAIT: begin
          if (wcnt_q == WC_W'(INSTR_CLKS - 1)) state_q <= ST_CONV;
          else                                  wcnt_q  <= wcnt_q + 1'b1;
        end
        ST_CONV: if (last) begin
          result_q <= next_code;
          state_q  <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // completion wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (last)       done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  end

  assign busy_o   = (state_q == ST_WAIT) || (state_q == ST_CONV);
  assign sample_o = (state_q == ST_IDLE);
  assign result_o = result_q;
  assign done_o   = done_q;

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(result_o));
  assert_switch_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sample_o);
  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_clr_i) |=> done_o);
  assert_resample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> sample_o);
  assert_done_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic go = 1'b0, done_clr = 1'b0, clk_sel = 1'b0, rc_tick = 1'b0;
  logic [2:0] div_sel = '0;
  logic [W-1:0] vin = '0, dac_code, result, exp_res;
  logic comp, sample, busy, done;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign comp = (vin >= dac_code);

  sar_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .go_i(go), .done_clr_i(done_clr),
    .clk_sel_i(clk_sel), .div_sel_i(div_sel), .rc_tick_i(rc_tick), .comp_i(comp),
    .dac_code_o(dac_code), .sample_o(sample), .result_o(result),
    .busy_o(busy), .done_o(done)
  );

  function automatic int div_of(input logic [2:0] s);
    return (s > 3'd5) ? 64 : (2 << s);
  endfunction

  function automatic logic [W-1:0] sar_model(input logic [W-1:0] v);
    logic [W-1:0] c = '0;
    for (int b = W - 1; b >= 0; b--) begin
      logic [W-1:0] t = c | (W'(1) << b);
      if (v >= t) c = t;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [W-1:0] v, input bit rc, input logic [2:0] sel,
                          input bit rc_rand, input bit poke_go);
    int k = 0, d = div_of(sel), hold_err = 0, exp_cyc;
    logic [W-1:0] want = sar_model(v);
    exp_cyc = rc ? 4 + 13 : 13 * d;
    @(negedge clk);
    vin = v; clk_sel = rc; div_sel = sel; go = 1'b1; done_clr = 1'b1; rc_tick = 1'b0;
    @(negedge clk);
    go = 1'b0; done_clr = 1'b0;
    chk(busy == 1'b1 && sample == 1'b0, "R2 busy/sample after go", {busy, sample}, 2);
    while (!done && k < 5000) begin
      if (result != exp_res) hold_err++;
      if (rc) rc_tick = rc_rand ? 1'($urandom % 2) : 1'b1;
      go = poke_go && (k == 5);
      if (!rc && k == d)
        chk(dac_code == 12'h800, "R5 first trial", dac_code, 12'h800);
      if (!rc && k == 2 * d)
        chk(dac_code == ((v >= 12'h800 ? 12'h800 : 12'h000) | 12'h400),
            "R5 second trial", dac_code, (v >= 12'h800 ? 12'h800 : 0) | 12'h400);
      @(negedge clk);
      k++;
    end
    rc_tick = 1'b0; go = 1'b0;
    chk(hold_err == 0, "R6 result held during conversion", hold_err, 0);
    if (!rc || !rc_rand)
      chk(k == exp_cyc, rc ? "R4 rc completion cycle" : "R3 divided completion cycle", k, exp_cyc);
    else
      chk(k >= exp_cyc, "R4 rc wait before ticks", k, exp_cyc);
    chk(result == want, "R5 result code", result, want);
    chk(busy == 1'b0 && done == 1'b1, "R7 busy clear, done set", {busy, done}, 1);
    chk(sample == 1'b0, "R8 sample low on completion cycle", sample, 0);
    @(negedge clk);
    chk(sample == 1'b1, "R8 sample back next clock", sample, 1);
    exp_res = want;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_res = '0;
    #(CLK_PERIOD * 2);
    chk(sample && !busy && !done && result == 0 && dac_code == 0, "R1 in reset",
        {sample, busy, done}, 4);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(sample && !busy && !done && result == 0, "R1 after reset", {sample, busy, done}, 4);

    // directed corners
    run_conv(12'h000, 1'b0, 3'd0, 1'b0, 1'b0);
    run_conv(12'hFFF, 1'b0, 3'd1, 1'b0, 1'b0);
    run_conv(12'h800, 1'b0, 3'd0, 1'b0, 1'b0);
    run_conv(12'h7FF, 1'b0, 3'd2, 1'b0, 1'b0);
    run_conv(12'h5A5, 1'b0, 3'd7, 1'b0, 1'b0);  // R3 clamp to 64
    run_conv(12'h123, 1'b0, 3'd5, 1'b0, 1'b0);
    run_conv(12'hABC, 1'b0, 3'd1, 1'b0, 1'b1);  // R9 go while busy
    run_conv(12'h3C3, 1'b1, 3'd0, 1'b0, 1'b0);  // R4 constant ticks
    run_conv(12'hC3C, 1'b1, 3'd0, 1'b0, 1'b1);  // R9 in rc mode

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] v = W'($urandom);
      if (i % 4 == 3) run_conv(v, 1'b1, 3'd0, 1'b1, 1'b0);
      else            run_conv(v, 1'b0, 3'($urandom % 4), 1'b0, 1'b0);
    end

    // R10: done survives a new go, cleared only by done_clr
    chk(done == 1'b1, "R10 done set before new go", done, 1);
    @(negedge clk); vin = 12'h222; clk_sel = 1'b0; div_sel = 3'd0; go = 1'b1;
    @(negedge clk); go = 1'b0;
    chk(done == 1'b1 && busy == 1'b1, "R10 go does not clear done", {done, busy}, 3);
    while (busy) @(negedge clk);
    exp_res = sar_model(12'h222);
    chk(result == exp_res, "R5 result after sticky run", result, exp_res);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10 done still set", done, 1);
    done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done == 1'b0, "R10 done_clr clears", done, 0);

    // R11: abort by reset mid conversion
    @(negedge clk); vin = 12'h999; go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (7) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!busy && sample && !done && result == 0 && dac_code == 0, "R11 abort",
        {busy, sample, done}, 2);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && sample, "R11 idle after abort", {busy, sample}, 1);
    exp_res = '0;
    run_conv(12'h456, 1'b0, 3'd0, 1'b0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule